// File: doc/BRIEF.md
# Banked cache-line memory responder

This block sits on the memory side of a banked cache and answers whole-line traffic. It keeps a word-addressed backing RAM. When the cache raises a request, the block can first store an evicted line. It then returns a complete refill line one cycle later, with a single-cycle ready pulse. Both lines travel as a packed two-dimensional array indexed by bank and word offset. Consecutive words of a line are spread across the banks by the low bits of their word address.

Only one request is handled at a time. A request that arrives while a refill is pending or being delivered is ignored. The cache must keep the request raised, or raise it again, until it is taken. Outside a delivery cycle the response array carries a fixed filler word, so a stale line is never presented as valid data. The number of banks, the words per bank and the RAM depth are parameters, and each must be a power of two.

Top module: `line_mem_responder`

## Requirements
- R1: While reset is high on a clock edge, and after that edge, `rsp_ready` is 0 and every slot of `rsp_line` holds 0x00506070.
- R2: A request accepted on edge k makes `rsp_ready` high after edge k+1 and low again after edge k+2.
- R3: A request is accepted only when `req_valid` is high, no refill is pending and `rsp_ready` is low. With `req_valid` held high, a new ready pulse therefore comes every third cycle.
- R4: When an accepted request has `req_wb` = 1, element e of the evicted line is written to byte address `req_ev_addr` + 4·e. It is taken from slot `wb_line[bank][offset]`, where bank and offset come from that word address as R6 defines.
- R5: The refill line is read at `req_rd_addr` after the same request's writeback. A refill from the address just written back returns the new data.
- R6: Element e of a line has word address w = (base >> 2) + e. Its bank is w AND (BANKS−1) and its offset is (w >> log2(BANKS)) AND (WPB−1). This holds for a base that is not aligned to a line.
- R7: In every cycle in which `rsp_ready` is low, all slots of `rsp_line` hold 0x00506070.
- R8: An accepted request with `req_wb` = 0 leaves the RAM unchanged, whatever `wb_line` and `req_ev_addr` carry.
- R9: RAM accesses use the word address modulo DEPTH, so a line that runs past the top of the RAM wraps to word 0.
- R10: Reset loads RAM word i with 0xC0DE0000 XOR i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_wb | input | 1 | Write the evicted line before the refill |
| req_ev_addr | input | 32 | Byte base address of the evicted line |
| req_rd_addr | input | 32 | Byte base address of the refill line |
| wb_line | input | BANKS·WPB·32 | Evicted line, packed [bank][offset][word] |
| rsp_ready | output | 1 | High for the single cycle that carries the refill |
| rsp_line | output | BANKS·WPB·32 | Refill line, packed [bank][offset][word]; filler when idle |

## Verification
The embedded assertions check the handshake on every cycle. Ready lasts one cycle and always follows a pending refill. A pending refill always delivers on the next edge. No request is taken during the delivery cycle. The filler word shows whenever ready is low. Data contents are not something a property can judge, because they depend on the bank/offset scatter, writeback-before-refill ordering, wrap-around and the reset image. The bench scenarios cover these: aligned and unaligned bases, refills from the evicted address and from a separate address, a line that wraps past the top of the RAM, and a request with the writeback flag clear.

// File: rtl/line_mem_pkg.sv
package line_mem_pkg;
   localparam int unsigned WORD_W = 32;
   typedef logic [WORD_W-1:0] word_t;

   // Word shown in every response slot outside a delivery cycle
   localparam word_t IDLE_FILL = 32'h0050_6070;

   // Reset image of the backing RAM
   function automatic word_t boot_word(input int unsigned idx);
      return 32'hC0DE_0000 ^ word_t'(idx);
   endfunction
endpackage

// File: rtl/line_slot_map.sv
// Maps one line element to its RAM word index and its bank/offset slot.
module line_slot_map #(
   parameter int unsigned BANKS = 4,
   parameter int unsigned WPB   = 4,
   parameter int unsigned DEPTH = 256,
   parameter int unsigned ELEM  = 0,
   localparam int unsigned LOG_B = $clog2(BANKS),
   localparam int unsigned BW    = (LOG_B > 0) ? LOG_B : 1,
   localparam int unsigned OW    = ($clog2(WPB) > 0) ? $clog2(WPB) : 1,
   localparam int unsigned AW    = ($clog2(DEPTH) > 0) ? $clog2(DEPTH) : 1
) (
   input  logic [31:0]   base,
   output logic [AW-1:0] ram_idx,
   output logic [BW-1:0] bank,
   output logic [OW-1:0] offs
);
   logic [29:0] wa;
   logic [29:0] bank_full;
   logic [29:0] offs_full;
   logic        unused_map;

   assign wa        = base[31:2] + 30'(ELEM);
   assign bank_full = wa & 30'(BANKS - 1);
   assign offs_full = (wa >> LOG_B) & 30'(WPB - 1);
   assign bank      = bank_full[BW-1:0];
   assign offs      = offs_full[OW-1:0];
   assign ram_idx   = wa[AW-1:0];
   assign unused_map = ^{base[1:0], bank_full, offs_full, wa};
endmodule

// File: rtl/line_backing_ram.sv
// Word RAM with a whole-line write port and a whole-line read port.
module line_backing_ram
   import line_mem_pkg::*;
#(
   parameter int unsigned N_ELEM = 16,
   parameter int unsigned DEPTH  = 256,
   localparam int unsigned AW    = ($clog2(DEPTH) > 0) ? $clog2(DEPTH) : 1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [N_ELEM-1:0][AW-1:0]     wr_idx,
   input  logic [N_ELEM-1:0][WORD_W-1:0] wr_data,
   input  logic [N_ELEM-1:0][AW-1:0]     rd_idx,
   output logic [N_ELEM-1:0][WORD_W-1:0] rd_data
);
   word_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= boot_word(i);
      end else if (wr_en) begin
         for (int e = 0; e < int'(N_ELEM); e++) mem[wr_idx[e]] <= wr_data[e];
      end
   end

   for (genvar e = 0; e < N_ELEM; e++) begin : g_rd
      assign rd_data[e] = mem[rd_idx[e]];
   end
endmodule

// File: rtl/line_mem_responder.sv
module line_mem_responder
   import line_mem_pkg::*;
#(
   parameter int unsigned BANKS = 4,
   parameter int unsigned WPB   = 4,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned N_ELEM = BANKS * WPB,
   localparam int unsigned BW = ($clog2(BANKS) > 0) ? $clog2(BANKS) : 1,
   localparam int unsigned OW = ($clog2(WPB) > 0) ? $clog2(WPB) : 1,
   localparam int unsigned AW = ($clog2(DEPTH) > 0) ? $clog2(DEPTH) : 1
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                req_valid,
   input  logic                                req_wb,
   input  logic [31:0]                         req_ev_addr,
   input  logic [31:0]                         req_rd_addr,
   input  logic [BANKS-1:0][WPB-1:0][WORD_W-1:0] wb_line,
   output logic                                rsp_ready,
   output logic [BANKS-1:0][WPB-1:0][WORD_W-1:0] rsp_line
);
   localparam logic [BANKS-1:0][WPB-1:0][WORD_W-1:0] FILL_LINE = {N_ELEM{IDLE_FILL}};

   if (BANKS == 0 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two");
   end
   if (WPB == 0 || (WPB & (WPB - 1)) != 0) begin : g_bad_wpb
      $error("WPB must be a power of two");
   end
   if (DEPTH < N_ELEM || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two no smaller than one line");
   end

   logic        pending;
   logic [31:0] rd_base;
   logic        accept;

   logic [N_ELEM-1:0][AW-1:0]     ev_idx, rd_idx;
   logic [N_ELEM-1:0][BW-1:0]     ev_bank, rd_bank;
   logic [N_ELEM-1:0][OW-1:0]     ev_offs, rd_offs;
   logic [N_ELEM-1:0][WORD_W-1:0] wr_data, rd_data;
   logic [BANKS-1:0][WPB-1:0][WORD_W-1:0] refill_line;

   assign accept = req_valid && !pending && !rsp_ready;

   for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
      line_slot_map #(.BANKS(BANKS), .WPB(WPB), .DEPTH(DEPTH), .ELEM(e)) u_ev_map (
         .base(req_ev_addr), .ram_idx(ev_idx[e]), .bank(ev_bank[e]), .offs(ev_offs[e]));
      line_slot_map #(.BANKS(BANKS), .WPB(WPB), .DEPTH(DEPTH), .ELEM(e)) u_rd_map (
         .base(rd_base), .ram_idx(rd_idx[e]), .bank(rd_bank[e]), .offs(rd_offs[e]));
      assign wr_data[e] = wb_line[ev_bank[e]][ev_offs[e]];
   end

   line_backing_ram #(.N_ELEM(N_ELEM), .DEPTH(DEPTH)) u_ram (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (accept && req_wb),
      .wr_idx  (ev_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   always_comb begin
      refill_line = FILL_LINE;
      for (int e = 0; e < int'(N_ELEM); e++) refill_line[rd_bank[e]][rd_offs[e]] = rd_data[e];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pending   <= 1'b0;
         rd_base   <= '0;
         rsp_ready <= 1'b0;
         rsp_line  <= FILL_LINE;
      end else begin
         rsp_ready <= pending;
         rsp_line  <= pending ? refill_line : FILL_LINE;
         pending   <= accept;
         if (accept) rd_base <= req_rd_addr;
      end
   end

   // R2: a pending refill is delivered on the very next edge
   a_r2_pending_delivers: assert property (@(posedge clk) disable iff (rst)
      pending |=> (rsp_ready && !pending));
   // R2: ready lasts exactly one cycle
   a_r2_ready_single: assert property (@(posedge clk) disable iff (rst)
      rsp_ready |=> !rsp_ready);
   // R2: ready never appears without a pending refill before it
   a_r2_ready_cause: assert property (@(posedge clk) disable iff (rst)
      rsp_ready |-> $past(pending));
   // R3: nothing is accepted in a delivery cycle
   a_r3_busy_blocks: assert property (@(posedge clk) disable iff (rst)
      rsp_ready |=> !pending);
   // R7: idle response carries the filler word
   a_r7_idle_fill: assert property (@(posedge clk) disable iff (rst)
      !rsp_ready |-> (rsp_line == FILL_LINE));
endmodule

// File: tb/line_mem_responder_bench.sv
`timescale 1ns/1ps
module line_mem_responder_bench;
   localparam int B = 4;
   localparam int W = 4;
   localparam int D = 256;
   localparam int N = B * W;
   localparam logic [31:0] FILL = 32'h0050_6070;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic req_valid = 1'b0;
   logic req_wb = 1'b0;
   logic [31:0] req_ev_addr = '0;
   logic [31:0] req_rd_addr = '0;
   logic [B-1:0][W-1:0][31:0] wb_line = '0;
   logic rsp_ready;
   logic [B-1:0][W-1:0][31:0] rsp_line;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   line_mem_responder #(.BANKS(B), .WPB(W), .DEPTH(D)) u_line_mem_responder (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_wb(req_wb),
      .req_ev_addr(req_ev_addr), .req_rd_addr(req_rd_addr), .wb_line(wb_line),
      .rsp_ready(rsp_ready), .rsp_line(rsp_line));

   // Behavioural reference model
   int unsigned ref_mem [D];
   bit          m_pend, m_ready;
   int unsigned m_rd;
   logic [31:0] m_line [B][W];

   function automatic int unsigned wa_of(int unsigned base, int e);
      return (base >> 2) + e;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < D; i++) ref_mem[i] = 32'hC0DE_0000 ^ i;
         m_pend <= 0; m_ready <= 0;
         for (int b = 0; b < B; b++) for (int o = 0; o < W; o++) m_line[b][o] <= FILL;
      end else begin
         bit acc;
         acc = req_valid && !m_pend && !m_ready;
         m_ready <= m_pend;
         for (int e = 0; e < N; e++) begin
            int unsigned w;
            w = wa_of(m_rd, e);
            m_line[w % B][(w / B) % W] <= m_pend ? ref_mem[w % D] : FILL;
         end
         if (acc && req_wb)
            for (int e = 0; e < N; e++) begin
               int unsigned w;
               w = wa_of(req_ev_addr, e);
               ref_mem[w % D] = wb_line[w % B][(w / B) % W];
            end
         if (acc) m_rd <= req_rd_addr;
         m_pend <= acc;
      end
   end

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) if (!rst && !done) begin
      checks++;
      if (rsp_ready !== m_ready) begin
         errors++;
         $display("FAIL R2 ready: actual=%0b expected=%0b", rsp_ready, m_ready);
      end
      for (int b = 0; b < B; b++) for (int o = 0; o < W; o++)
         if (rsp_line[b][o] !== m_line[b][o]) begin
            errors++;
            $display("FAIL %s slot[%0d][%0d]: actual=%h expected=%h",
                     m_ready ? "R5/R6" : "R7", b, o, rsp_line[b][o], m_line[b][o]);
         end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_line(input int unsigned base, input int unsigned seed);
      for (int e = 0; e < N; e++) begin
         int unsigned w;
         w = wa_of(base, e);
         wb_line[w % B][(w / B) % W] = seed + e;
      end
   endtask

   // Issue one request; returns at the negedge where the refill is visible
   task automatic issue(input bit wb, input int unsigned ev, input int unsigned rd);
      @(negedge clk);
      req_valid = 1; req_wb = wb; req_ev_addr = ev; req_rd_addr = rd;
      @(negedge clk);
      req_valid = 0; req_wb = 0;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      int pulses;
      repeat (3) @(negedge clk);
      rst = 0;
      // R1: reset state
      check(rsp_ready == 0, "R1 ready after reset", {31'b0, rsp_ready}, 0);
      check(rsp_line[2][3] == FILL, "R1 filler after reset", rsp_line[2][3], FILL);

      // R10 and R2: plain refill of boot image
      issue(0, 0, 32'h40);
      check(rsp_ready == 1, "R2 ready one cycle after accept", {31'b0, rsp_ready}, 1);
      check(rsp_line[0][0] == 32'hC0DE0010, "R10 boot word 16", rsp_line[0][0], 32'hC0DE0010);
      check(rsp_line[1][0] == 32'hC0DE0011, "R10 boot word 17", rsp_line[1][0], 32'hC0DE0011);
      @(negedge clk);
      check(rsp_ready == 0, "R2 ready drops after one cycle", {31'b0, rsp_ready}, 0);
      check(rsp_line[0][0] == FILL, "R7 filler after delivery", rsp_line[0][0], FILL);

      // R4/R5: writeback then refill of the same line
      set_line(32'h100, 32'hA000_0000);
      issue(1, 32'h100, 32'h100);
      check(rsp_line[1][1] == 32'hA0000005, "R5 refill sees writeback", rsp_line[1][1], 32'hA0000005);

      // R4/R5: writeback with refill from a separate address
      set_line(32'h200, 32'hD000_0000);
      issue(1, 32'h200, 32'h40);
      check(rsp_line[0][0] == 32'hC0DE0010, "R5 separate read address", rsp_line[0][0], 32'hC0DE0010);
      issue(0, 0, 32'h200);
      check(rsp_line[3][2] == 32'hD000000B, "R4 evicted slot scatter", rsp_line[3][2], 32'hD000000B);

      // R6: unaligned base
      issue(0, 0, 32'h104);
      check(rsp_line[1][0] == 32'hA0000001, "R6 unaligned element 0", rsp_line[1][0], 32'hA0000001);
      check(rsp_line[0][1] == 32'hA0000004, "R6 unaligned element 3", rsp_line[0][1], 32'hA0000004);

      // R9: wrap past the top of the RAM
      set_line(32'h3F8, 32'hB000_0000);
      issue(1, 32'h3F8, 32'h0);
      check(rsp_line[0][0] == 32'hB0000002, "R9 wrapped word 0", rsp_line[0][0], 32'hB0000002);

      // R8: flag clear leaves RAM untouched
      set_line(32'h300, 32'hEEEE_0000);
      issue(0, 32'h300, 32'h300);
      check(rsp_line[0][0] == 32'hC0DE00C0, "R8 no write when flag clear", rsp_line[0][0], 32'hC0DE00C0);

      // R3: held valid yields one pulse every third cycle
      @(negedge clk);
      req_valid = 1; req_rd_addr = 32'h40;
      pulses = 0;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (rsp_ready) pulses++;
      end
      req_valid = 0;
      check(pulses == 3, "R3 pulses with valid held", pulses, 3);
      repeat (3) @(negedge clk);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule